// File: doc/BRIEF.md
# ECP Reverse-Channel Byte Receiver with Run-Length Expansion

This block is the host side of a parallel-port link that runs in the enhanced bidirectional reverse direction. A request asks for a number of bytes. If the port still faces forward, the block first turns the bus around. It then reads peripheral bytes one at a time with the nAck/nAutoFd interlock and delivers them on a valid/ready byte stream. The Busy line, sampled with each byte, marks the byte as payload or as a command.

Commands are decoded inside the block. A command with its top bit set addresses a channel, and the block drops it. Any other command loads a repeat count. The next payload byte is then delivered once, and again as many more times as the count says. Repeats that do not fit in the current request stay pending and are delivered at the start of the next request. This lets a consumer treat the link as a plain byte pipe.

A done pulse closes every request. It carries the number of bytes delivered and a flag that tells a handshake timeout from a normal end. One clock cycle is one timing tick. While the block is idle, a separate exit strobe returns the port to the forward direction.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, host_nautofd and host_ninit are high, data_dir_in and out_valid are low, and req_ready is high.
- R2: A request accepted while the port faces forward drives host_nautofd low on the next cycle. host_ninit stays high for SETUP_TICKS cycles. Then host_ninit goes low and data_dir_in goes high on the same cycle.
- R3: After the turnaround the block samples peer_perror for up to RESP_TICKS cycles. If it never sees peer_perror low, the request ends with done_timeout = 1 and done_count = 0. With the defaults, done appears 6 cycles after data_dir_in rises.
- R4: When peer_nack is seen low, a high peer_busy marks the peer_data byte as payload and it is delivered on the output stream. A low peer_busy marks it as a command, and a command never reaches the output.
- R5: A command with bit DATA_W-1 set is a channel address and changes nothing. A command with that bit clear loads bits DATA_W-2..0 as a repeat count N.
- R6: After a repeat command with count N, the next payload byte is delivered 1+N times in a row.
- R7: Pending repeats are delivered before any new bus byte is read. They never exceed the bytes still owed to the request, and any left over are delivered first in the next request.
- R8: After each bus byte the block raises host_nautofd and samples peer_nack for up to RESP_TICKS cycles. When peer_nack goes high, host_nautofd returns low. If peer_nack stays low, the request ends with done_timeout = 1.
- R9: If peer_nack is not seen low within IDLE_TICKS cycles while a byte is awaited, the request ends with done_timeout = 0 and reports the bytes delivered so far.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R11: mode_exit while idle with no request clears the pending repeat state and returns the port forward: host_nautofd and host_ninit high, data_dir_in low.
- R12: done pulses for one cycle at the end of every request. done_count equals the number of stream transfers in that request and never exceeds req_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_len | input | LEN_W | Number of bytes requested |
| req_ready | output | 1 | Block idle and able to take a request |
| mode_exit | input | 1 | Leave reverse mode (honoured when idle with no request) |
| done | output | 1 | One-cycle pulse at the end of a request |
| done_count | output | LEN_W | Bytes delivered by the finished request |
| done_timeout | output | 1 | Request ended on a turnaround or acknowledge timeout |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Output byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| peer_data | input | DATA_W | Parallel data bus from the peripheral |
| peer_nack | input | 1 | Peripheral strobe, active low |
| peer_busy | input | 1 | Payload (high) or command (low) marker |
| peer_perror | input | 1 | Peripheral turnaround acknowledge, active low |
| host_nautofd | output | 1 | Host acknowledge line |
| host_ninit | output | 1 | Host reverse-request line, low in reverse |
| data_dir_in | output | 1 | Data bus driver direction, 1 = bus driven by peripheral |

## Verification
The hardest situation to reach is a run of repeats that is split across request boundaries while the peripheral is already presenting its next byte. In that case the block must drain the stored repeats without touching the bus, and an exit between requests must discard what is left. The stimulus gets there with a scripted peripheral and deliberately short requests. The lengths are chosen so that a count of 3 leaves one repeat for the next request and a count of 5 leaves two. After that, an exit and a fresh turnaround must yield the peripheral's pending byte and not the stale repeat. Separate phases hold PError or nAck to force both timeout paths.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN_SETUP,
    ST_TURN_WAIT,
    ST_FETCH,
    ST_WAIT_ACK,
    ST_PUSH,
    ST_ACK,
    ST_REPEAT
  } rx_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ecp_rx_timer.sv
module ecp_rx_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  // Counts cycles spent in the current state; saturates at all ones.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ecp_rx_rle.sv
module ecp_rx_rle #(
  parameter int DATA_W = 8,
  localparam int RUN_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cmd_load,
  input  logic [RUN_W-1:0]  cmd_count,
  input  logic              data_load,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              take,
  output logic              pending,
  output logic [DATA_W-1:0] rep_byte
);

  logic [RUN_W-1:0]  run_q;
  logic              arm_q;   // count loaded, waiting for the byte to repeat
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q  <= '0;
      arm_q  <= 1'b0;
      byte_q <= '0;
    end else if (cmd_load) begin
      run_q <= cmd_count;
      arm_q <= 1'b1;
    end else if (data_load && arm_q) begin
      byte_q <= data_byte;
      arm_q  <= 1'b0;
    end else if (take && run_q != '0) begin
      run_q <= run_q - 1'b1;
    end
  end

  assign pending  = (run_q != '0) && !arm_q;
  assign rep_byte = byte_q;

endmodule

// File: rtl/ecp_rx_ctrl.sv
module ecp_rx_ctrl
  import ecp_rx_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000,
  parameter int TW          = 11,
  localparam int RUN_W      = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              mode_exit,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic              done_timeout,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] peer_data,
  input  logic              peer_nack,
  input  logic              peer_busy,
  input  logic              peer_perror,
  output logic              host_nautofd,
  output logic              host_ninit,
  output logic              data_dir_in,
  input  logic [TW-1:0]     tmr_cnt,
  output logic              tmr_clr,
  input  logic              rle_pending,
  input  logic [DATA_W-1:0] rle_byte,
  output logic              rle_cmd_load,
  output logic [RUN_W-1:0]  rle_cmd_count,
  output logic              rle_data_load,
  output logic              rle_take,
  output logic              rle_clear
);

  localparam logic [TW-1:0] SETUP_LAST = TW'(SETUP_TICKS - 1);
  localparam logic [TW-1:0] RESP_LAST  = TW'(RESP_TICKS - 1);
  localparam logic [TW-1:0] IDLE_LAST  = TW'(IDLE_TICKS - 1);

  rx_state_t state_q, state_d;

  logic              nautofd_q, ninit_q, dir_q;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;
  logic              done_q, done_to_q;
  logic [LEN_W-1:0]  done_cnt_q;
  logic [LEN_W-1:0]  len_q, rem_q;

  logic accept, do_exit, finish, fin_to, xfer;
  logic turn_go, rep_go, ack_enter, ack_leave;

  always_comb begin
    state_d       = state_q;
    accept        = 1'b0;
    do_exit       = 1'b0;
    finish        = 1'b0;
    fin_to        = 1'b0;
    xfer          = 1'b0;
    rle_cmd_load  = 1'b0;
    rle_data_load = 1'b0;
    rle_take      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = dir_q ? ST_FETCH : ST_TURN_SETUP;
        end else if (mode_exit) begin
          do_exit = 1'b1;
        end
      end
      ST_TURN_SETUP: begin
        if (tmr_cnt == SETUP_LAST) state_d = ST_TURN_WAIT;
      end
      ST_TURN_WAIT: begin
        if (!peer_perror) begin
          state_d = ST_FETCH;
        end else if (tmr_cnt == RESP_LAST) begin
          finish = 1'b1;
          fin_to = 1'b1;
        end
      end
      ST_FETCH: begin
        if (rem_q == '0)      finish  = 1'b1;
        else if (rle_pending) state_d = ST_REPEAT;
        else                  state_d = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (!peer_nack) begin
          if (peer_busy) begin
            rle_data_load = 1'b1;
            state_d       = ST_PUSH;
          end else begin
            rle_cmd_load = !peer_data[DATA_W-1];
            state_d      = ST_ACK;
          end
        end else if (tmr_cnt == IDLE_LAST) begin
          finish = 1'b1;
        end
      end
      ST_PUSH: begin
        if (out_ready) begin
          xfer    = 1'b1;
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        if (peer_nack) begin
          state_d = ST_FETCH;
        end else if (tmr_cnt == RESP_LAST) begin
          finish = 1'b1;
          fin_to = 1'b1;
        end
      end
      ST_REPEAT: begin
        if (out_ready) begin
          xfer     = 1'b1;
          rle_take = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish) state_d = ST_IDLE;
  end

  assign turn_go   = (state_q == ST_TURN_SETUP) && (state_d == ST_TURN_WAIT);
  assign rep_go    = (state_q == ST_FETCH) && (state_d == ST_REPEAT);
  assign ack_enter = (state_q != ST_ACK) && (state_d == ST_ACK);
  assign ack_leave = (state_q == ST_ACK) && (state_d == ST_FETCH);
  assign tmr_clr   = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      nautofd_q   <= 1'b1;
      ninit_q     <= 1'b1;
      dir_q       <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      done_q      <= 1'b0;
      done_to_q   <= 1'b0;
      done_cnt_q  <= '0;
      len_q       <= '0;
      rem_q       <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        len_q <= req_len;
        rem_q <= req_len;
        if (!dir_q) nautofd_q <= 1'b0;
      end
      if (do_exit) begin
        nautofd_q <= 1'b1;
        ninit_q   <= 1'b1;
        dir_q     <= 1'b0;
      end
      if (turn_go) begin
        ninit_q <= 1'b0;
        dir_q   <= 1'b1;
      end
      if (rep_go) begin
        out_valid_q <= 1'b1;
        out_data_q  <= rle_byte;
      end
      if (rle_data_load) begin
        out_valid_q <= 1'b1;
        out_data_q  <= peer_data;
      end
      if (xfer) begin
        out_valid_q <= 1'b0;
        rem_q       <= rem_q - 1'b1;
      end
      if (ack_enter) nautofd_q <= 1'b1;
      if (ack_leave) nautofd_q <= 1'b0;
      if (finish) begin
        done_cnt_q <= len_q - rem_q;
        done_to_q  <= fin_to;
        nautofd_q  <= 1'b0;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign done          = done_q;
  assign done_count    = done_cnt_q;
  assign done_timeout  = done_to_q;
  assign out_valid     = out_valid_q;
  assign out_data      = out_data_q;
  assign host_nautofd  = nautofd_q;
  assign host_ninit    = ninit_q;
  assign data_dir_in   = dir_q;
  assign rle_cmd_count = peer_data[RUN_W-1:0];
  assign rle_clear     = do_exit;

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rx_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              mode_exit,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic              done_timeout,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] peer_data,
  input  logic              peer_nack,
  input  logic              peer_busy,
  input  logic              peer_perror,
  output logic              host_nautofd,
  output logic              host_ninit,
  output logic              data_dir_in
);

  localparam int TMAX  = max3(SETUP_TICKS, RESP_TICKS, IDLE_TICKS);
  localparam int TW    = $clog2(TMAX + 1);
  localparam int RUN_W = DATA_W - 1;

  logic [TW-1:0]     tmr_cnt;
  logic              tmr_clr;
  logic              rle_pending, rle_cmd_load, rle_data_load, rle_take, rle_clear;
  logic [DATA_W-1:0] rle_byte;
  logic [RUN_W-1:0]  rle_cmd_count;

  ecp_rx_timer #(.W(TW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (tmr_cnt)
  );

  ecp_rx_rle #(.DATA_W(DATA_W)) u_rle (
    .clk       (clk),
    .rst       (rst),
    .clear     (rle_clear),
    .cmd_load  (rle_cmd_load),
    .cmd_count (rle_cmd_count),
    .data_load (rle_data_load),
    .data_byte (peer_data),
    .take      (rle_take),
    .pending   (rle_pending),
    .rep_byte  (rle_byte)
  );

  ecp_rx_ctrl #(
    .LEN_W       (LEN_W),
    .DATA_W      (DATA_W),
    .SETUP_TICKS (SETUP_TICKS),
    .RESP_TICKS  (RESP_TICKS),
    .IDLE_TICKS  (IDLE_TICKS),
    .TW          (TW)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_len       (req_len),
    .req_ready     (req_ready),
    .mode_exit     (mode_exit),
    .done          (done),
    .done_count    (done_count),
    .done_timeout  (done_timeout),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_ready     (out_ready),
    .peer_data     (peer_data),
    .peer_nack     (peer_nack),
    .peer_busy     (peer_busy),
    .peer_perror   (peer_perror),
    .host_nautofd  (host_nautofd),
    .host_ninit    (host_ninit),
    .data_dir_in   (data_dir_in),
    .tmr_cnt       (tmr_cnt),
    .tmr_clr       (tmr_clr),
    .rle_pending   (rle_pending),
    .rle_byte      (rle_byte),
    .rle_cmd_load  (rle_cmd_load),
    .rle_cmd_count (rle_cmd_count),
    .rle_data_load (rle_data_load),
    .rle_take      (rle_take),
    .rle_clear     (rle_clear)
  );

endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_ready,
  input logic              mode_exit,
  input logic              done,
  input logic [LEN_W-1:0]  done_count,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              host_nautofd,
  input logic              host_ninit,
  input logic              data_dir_in
);

  logic [LEN_W-1:0] len_seen;

  always_ff @(posedge clk) begin
    if (rst) len_seen <= '0;
    else if (req_valid && req_ready) len_seen <= req_len;
  end

  // R1: first cycle out of reset shows the idle forward state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (host_nautofd && host_ninit && !data_dir_in && !out_valid && req_ready));

  // R2: the bus direction flips only after nAutoFd is already low
  p_turn_order_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(data_dir_in) |-> !host_nautofd);

  // R4: bytes are delivered only while the bus faces the host
  p_out_reverse_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> data_dir_in);

  // R10: a stalled output byte is held
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11: exit restores the forward idle lines
  p_exit_forward_r11: assert property (@(posedge clk) disable iff (rst)
    (req_ready && mode_exit && !req_valid) |=> (!data_dir_in && host_ninit && host_nautofd));

  // R12: reported count never exceeds the request
  p_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_count <= len_seen));

endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_len      (req_len),
  .req_ready    (req_ready),
  .mode_exit    (mode_exit),
  .done         (done),
  .done_count   (done_count),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ready    (out_ready),
  .host_nautofd (host_nautofd),
  .host_ninit   (host_ninit),
  .data_dir_in  (data_dir_in)
);

// File: tb/ecp_rev_rx_bench.sv
module ecp_rev_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;
  localparam int DATA_W     = 8;
  localparam int NSCRIPT    = 9;
  localparam int NEXP       = 13;

  // Peripheral script: bit 8 = Busy (1 payload, 0 command), bits 7..0 = bus byte
  localparam logic [8:0] SCRIPT [NSCRIPT] = '{
    9'h111, 9'h003, 9'h1A5, 9'h085, 9'h122, 9'h005, 9'h13C, 9'h144, 9'h15A
  };
  // Expected output stream over all requests
  localparam logic [7:0] EXPECT [NEXP] = '{
    8'h11, 8'hA5, 8'hA5, 8'hA5,
    8'hA5, 8'h22, 8'h3C, 8'h3C, 8'h3C, 8'h3C,
    8'h3C,
    8'h44,
    8'h5A
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready;
  logic mode_exit = 1'b0;
  logic done;
  logic [LEN_W-1:0] done_count;
  logic done_timeout;
  logic out_valid;
  logic [DATA_W-1:0] out_data;
  logic out_ready = 1'b1;
  logic [DATA_W-1:0] peer_data = '0;
  logic peer_nack = 1'b1;
  logic peer_busy = 1'b0;
  logic peer_perror = 1'b1;
  logic host_nautofd, host_ninit, data_dir_in;

  int n_chk = 0;
  int n_fail = 0;
  int got_n = 0;
  int p_idx = 0;
  int p_st = 0;
  int p_limit = 0;
  bit p_hold_perror = 1'b1;
  bit p_hold_nack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_rev_rx u_ecp_rev_rx (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_len      (req_len),
    .req_ready    (req_ready),
    .mode_exit    (mode_exit),
    .done         (done),
    .done_count   (done_count),
    .done_timeout (done_timeout),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ready    (out_ready),
    .peer_data    (peer_data),
    .peer_nack    (peer_nack),
    .peer_busy    (peer_busy),
    .peer_perror  (peer_perror),
    .host_nautofd (host_nautofd),
    .host_ninit   (host_ninit),
    .data_dir_in  (data_dir_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Peripheral model, acting on the falling edge
  always @(negedge clk) begin
    peer_perror <= p_hold_perror ? 1'b1 : !(data_dir_in && !host_ninit);
    case (p_st)
      0: if (data_dir_in && !host_nautofd && !peer_perror && p_idx < p_limit) begin
           peer_data <= SCRIPT[p_idx][7:0];
           peer_busy <= SCRIPT[p_idx][8];
           peer_nack <= 1'b0;
           p_st      <= 1;
         end
      1: if (data_dir_in && host_nautofd && !p_hold_nack) begin
           peer_nack <= 1'b1;
           p_idx     <= p_idx + 1;
           p_st      <= 2;
         end
      default: if (!host_nautofd) p_st <= 0;
    endcase
  end

  // Output stream monitor: R4 R5 R6 R7
  always begin
    @(negedge clk);
    #1;
    if (out_valid && out_ready) begin
      if (got_n < NEXP)
        check(out_data == EXPECT[got_n], "R4 R5 R6 R7 stream byte", int'(out_data), int'(EXPECT[got_n]));
      else
        check(1'b0, "R4 R6 extra stream byte", int'(out_data), 0);
      got_n++;
    end
  end

  task automatic issue(input int n);
    req_valid = 1'b1;
    req_len   = LEN_W'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 5000);
    check(done, "R12 done pulse seen", int'(done), 1);
  endtask

  task automatic do_exit();
    mode_exit = 1'b1;
    @(negedge clk);
    mode_exit = 1'b0;
    check(host_nautofd && host_ninit && !data_dir_in, "R11 forward lines after exit",
          {host_nautofd, host_ninit, data_dir_in}, 3'b110);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(host_nautofd == 1'b1, "R1 nautofd", int'(host_nautofd), 1);
    check(host_ninit == 1'b1, "R1 ninit", int'(host_ninit), 1);
    check(data_dir_in == 1'b0, "R1 dir", int'(data_dir_in), 0);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);

    // Turnaround with PError held high: R2 timing, R3 timeout
    issue(4);
    check(!host_nautofd && host_ninit && !data_dir_in, "R2 nautofd low first",
          {host_nautofd, host_ninit, data_dir_in}, 3'b010);
    @(negedge clk);
    check(!host_ninit && data_dir_in, "R2 ninit low with dir", {host_ninit, data_dir_in}, 2'b01);
    wait_done(lat);
    check(lat == 6, "R3 turnaround timeout latency", lat, 6);
    check(done_timeout == 1'b1, "R3 timeout flag", int'(done_timeout), 1);
    check(done_count == 0, "R3 count", int'(done_count), 0);

    do_exit();
    p_hold_perror = 1'b0;
    p_limit       = 8;

    // Request 1 with backpressure on the first byte
    out_ready = 1'b0;
    issue(4);
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
    check(out_data == 8'h11, "R10 data held", int'(out_data), 8'h11);
    out_ready = 1'b1;
    wait_done(lat);
    check(done_count == 4, "R7 R12 request 1 count", int'(done_count), 4);
    check(done_timeout == 1'b0, "R12 request 1 flag", int'(done_timeout), 0);

    // Request 2 starts on the leftover repeat
    issue(6);
    wait_done(lat);
    check(done_count == 6, "R7 request 2 count", int'(done_count), 6);

    // Request 3 takes one of two leftover repeats
    issue(1);
    wait_done(lat);
    check(done_count == 1, "R7 request 3 count", int'(done_count), 1);

    // Exit discards the remaining repeat
    do_exit();

    // Request 4: fresh turnaround, one byte, then idle timeout
    issue(2);
    wait_done(lat);
    check(done_count == 1, "R9 R11 request 4 count", int'(done_count), 1);
    check(done_timeout == 1'b0, "R9 quiet end flag", int'(done_timeout), 0);

    // Request 5: peripheral never releases nAck
    p_hold_nack = 1'b1;
    p_limit     = 9;
    issue(1);
    wait_done(lat);
    check(done_count == 1, "R8 request 5 count", int'(done_count), 1);
    check(done_timeout == 1'b1, "R8 ack timeout flag", int'(done_timeout), 1);
    check(host_nautofd == 1'b0, "R8 nautofd low after end", int'(host_nautofd), 0);

    @(negedge clk);
    check(got_n == NEXP, "R6 R7 total stream bytes", got_n, NEXP);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

endmodule